// File: doc/BRIEF.md
# Instruction Exception Cause Classifier

This block sits at the completion point of an instruction pipeline. It looks at the decode attributes of the instruction about to complete and decides which synchronous exception, if any, that instruction raises. The attributes are a valid strobe, class flags and a special-register number. The machine-state privilege bit and floating-point enable bit are also inputs. The result is registered, so it appears one clock after the strobe.

The block never raises a floating-point exception of any kind, and it never raises an illegal-instruction program exception. Floating-point instructions and unimplemented or illegal instructions all go to a single software-emulation trap. User-mode attempts at privileged work raise the privileged program exception. Privileged work means a privileged-only instruction, or a special-register move to a protected register. A register is protected when the top bit of its number is set. This holds whether the register lives on the core or is mapped outside it. Each request comes with a vector offset and a reason code for the save-register image. Flushing the pipeline, writing the save registers and choosing the vector base are left to the surrounding logic.

Top module: `insn_cause_classifier`

## Requirements
- R1: A valid floating-point instruction raises `req_emul` one cycle later, whatever the level of `msr_fp`.
- R2: A valid unimplemented or illegal instruction raises `req_emul`; it never raises `req_priv`.
- R3: A valid privileged-only instruction raises `req_priv` when `msr_pr` is 1, and raises nothing when `msr_pr` is 0.
- R4: A valid special-register move whose `spr_num[9]` (the top bit of the number) is 1 raises `req_priv` when `msr_pr` is 1, and raises nothing when `msr_pr` is 0.
- R5: A valid special-register move with `spr_num[9]` equal to 0 raises no request in either privilege mode. The lower nine bits of the number have no effect.
- R6: `vec_off` is 0x00700 together with `req_priv`, 0x01000 together with `req_emul`, and 0 when no request is raised.
- R7: `reason` is 0x00040000 together with `req_priv`, and 0 otherwise. This value is bit 13 of the 32-bit image, counted from the most significant bit as bit 0.
- R8: When emulation and privilege conditions both apply, only `req_emul` is raised. At most one request bit is high in any cycle.
- R9: While `in_valid` is 0, no request is raised in the following cycle, whatever the other inputs are.
- R10: Outputs change only at a clock edge, one cycle after the inputs are sampled. While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The instruction attributes are meaningful this cycle |
| is_fp | input | 1 | The instruction is a floating-point instruction |
| is_unimpl | input | 1 | The instruction is unimplemented or illegal |
| is_priv_only | input | 1 | The instruction may only run in supervisor mode |
| is_spr_move | input | 1 | The instruction moves to or from a special register |
| spr_num | input | 10 | Special-register number; bit 9 marks a protected register |
| msr_pr | input | 1 | Privilege state, 1 = user mode |
| msr_fp | input | 1 | Floating-point enable, which has no effect on the result |
| req_emul | output | 1 | Software-emulation exception request |
| req_priv | output | 1 | Privileged-instruction program exception request |
| reason | output | 32 | Reason bits for the save-register image |
| vec_off | output | 20 | Vector offset of the raised exception |

## Verification
The emulation trap and the privileged check can both apply to the same instruction. An example is a floating-point or illegal instruction that is also flagged privileged-only or as a protected register move while in user mode. The bench creates every such overlap by sweeping all combinations of the class flags, the privilege and enable bits, and the protected bit of the register number. In each case it expects only the emulation request, the emulation offset and a zero reason code. A checker also requires that the two request bits are never high together.

// File: rtl/exc_cls_pkg.sv
package exc_cls_pkg;

    localparam int RSN_W          = 32;
    localparam int VEC_W          = 20;
    localparam int PRIV_BE_BIT    = 13;
    localparam logic [VEC_W-1:0] VEC_PROGRAM = 20'h00700;
    localparam logic [VEC_W-1:0] VEC_EMULATE = 20'h01000;
    localparam logic [RSN_W-1:0] RSN_PRIV    =
        RSN_W'(1) << (RSN_W - 1 - PRIV_BE_BIT);

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_EMUL = 2'd1,
        CAUSE_PRIV = 2'd2
    } cause_e;

    typedef struct packed {
        logic fp;
        logic unimpl;
        logic priv_only;
        logic spr_move;
    } insn_cls_t;

    // Emulation outranks the privilege check.
    function automatic cause_e pick_cause(input logic valid,
                                          input logic emul_hit,
                                          input logic priv_hit);
        if (!valid)        return CAUSE_NONE;
        else if (emul_hit) return CAUSE_EMUL;
        else if (priv_hit) return CAUSE_PRIV;
        else               return CAUSE_NONE;
    endfunction

    function automatic logic [VEC_W-1:0] vector_of(input cause_e c);
        case (c)
            CAUSE_EMUL: return VEC_EMULATE;
            CAUSE_PRIV: return VEC_PROGRAM;
            default:    return '0;
        endcase
    endfunction

    function automatic logic [RSN_W-1:0] reason_of(input cause_e c);
        return (c == CAUSE_PRIV) ? RSN_PRIV : '0;
    endfunction

endpackage

// File: rtl/exc_spr_gate.sv
module exc_spr_gate #(
    parameter int SPR_W = 10
) (
    input  logic             is_spr_move,
    input  logic [SPR_W-1:0] spr_num,
    output logic             spr_protected
);
    localparam int PROT_BIT = SPR_W - 1;

    always_comb begin
        spr_protected = is_spr_move & spr_num[PROT_BIT];
    end
endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
    import exc_cls_pkg::*;
(
    input  logic      in_valid,
    input  insn_cls_t cls,
    input  logic      spr_protected,
    input  logic      msr_pr,
    input  logic      msr_fp,
    output cause_e    cause
);
    logic [1:0] fp_by_enable;
    logic       fp_emul;
    logic       emul_hit;
    logic       priv_hit;

    always_comb begin
        // Both enable states route a floating-point instruction to emulation.
        fp_by_enable = {cls.fp, cls.fp};
        fp_emul      = fp_by_enable[msr_fp];
        emul_hit     = fp_emul | cls.unimpl;
        priv_hit     = msr_pr & (cls.priv_only | spr_protected);
        cause        = pick_cause(in_valid, emul_hit, priv_hit);
    end
endmodule

// File: rtl/exc_out_reg.sv
module exc_out_reg
    import exc_cls_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cause_e           cause,
    output logic             req_emul,
    output logic             req_priv,
    output logic [RSN_W-1:0] reason,
    output logic [VEC_W-1:0] vec_off
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_emul <= 1'b0;
            req_priv <= 1'b0;
            reason   <= '0;
            vec_off  <= '0;
        end else begin
            req_emul <= (cause == CAUSE_EMUL);
            req_priv <= (cause == CAUSE_PRIV);
            reason   <= reason_of(cause);
            vec_off  <= vector_of(cause);
        end
    end
endmodule

// File: rtl/insn_cause_classifier.sv
module insn_cause_classifier
    import exc_cls_pkg::*;
#(
    parameter int SPR_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             is_fp,
    input  logic             is_unimpl,
    input  logic             is_priv_only,
    input  logic             is_spr_move,
    input  logic [SPR_W-1:0] spr_num,
    input  logic             msr_pr,
    input  logic             msr_fp,
    output logic             req_emul,
    output logic             req_priv,
    output logic [31:0]      reason,
    output logic [19:0]      vec_off
);
    insn_cls_t cls;
    logic      spr_protected;
    cause_e    cause;

    always_comb begin
        cls.fp        = is_fp;
        cls.unimpl    = is_unimpl;
        cls.priv_only = is_priv_only;
        cls.spr_move  = is_spr_move;
    end

    exc_spr_gate #(.SPR_W(SPR_W)) u_spr_gate (
        .is_spr_move   (cls.spr_move),
        .spr_num       (spr_num),
        .spr_protected (spr_protected)
    );

    exc_cause_sel u_cause_sel (
        .in_valid      (in_valid),
        .cls           (cls),
        .spr_protected (spr_protected),
        .msr_pr        (msr_pr),
        .msr_fp        (msr_fp),
        .cause         (cause)
    );

    exc_out_reg u_out_reg (
        .clk      (clk),
        .rst      (rst),
        .cause    (cause),
        .req_emul (req_emul),
        .req_priv (req_priv),
        .reason   (reason),
        .vec_off  (vec_off)
    );
endmodule

// File: rtl/insn_cause_classifier_chk.sv
module insn_cause_classifier_chk #(
    parameter int SPR_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             is_fp,
    input logic             is_unimpl,
    input logic             is_priv_only,
    input logic             is_spr_move,
    input logic [SPR_W-1:0] spr_num,
    input logic             msr_pr,
    input logic             msr_fp,
    input logic             req_emul,
    input logic             req_priv,
    input logic [31:0]      reason,
    input logic [19:0]      vec_off
);
    p_fp_emul_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_fp) |=> (req_emul && !req_priv));

    p_unimpl_emul_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_unimpl) |=> (req_emul && !req_priv));

    p_priv_only_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_priv_only && msr_pr && !is_fp && !is_unimpl) |=> req_priv);

    p_spr_protect_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_spr_move && spr_num[SPR_W-1] && msr_pr && !is_fp && !is_unimpl)
        |=> req_priv);

    p_spr_open_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_spr_move && !spr_num[SPR_W-1] && !is_priv_only && !is_fp && !is_unimpl)
        |=> (!req_emul && !req_priv));

    p_vec_priv_r6: assert property (@(posedge clk) disable iff (rst)
        req_priv |-> (vec_off == 20'h00700));

    p_vec_emul_r6: assert property (@(posedge clk) disable iff (rst)
        req_emul |-> (vec_off == 20'h01000));

    p_reason_r7: assert property (@(posedge clk) disable iff (rst)
        req_priv |-> (reason == 32'h0004_0000));

    p_one_request_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_emul, req_priv}));

    p_no_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!req_emul && !req_priv && vec_off == 20'h0));

    p_user_free_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !msr_pr) |=> !req_priv);
endmodule

bind insn_cause_classifier insn_cause_classifier_chk #(.SPR_W(SPR_W)) u_chk (.*);

// File: tb/insn_cause_classifier_bench.sv
module insn_cause_classifier_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, is_fp, is_unimpl, is_priv_only, is_spr_move;
    logic [9:0]  spr_num;
    logic        msr_pr, msr_fp;
    logic        req_emul, req_priv;
    logic [31:0] reason;
    logic [19:0] vec_off;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    insn_cause_classifier u_insn_cause_classifier (
        .clk(clk), .rst(rst), .in_valid(in_valid), .is_fp(is_fp),
        .is_unimpl(is_unimpl), .is_priv_only(is_priv_only),
        .is_spr_move(is_spr_move), .spr_num(spr_num), .msr_pr(msr_pr),
        .msr_fp(msr_fp), .req_emul(req_emul), .req_priv(req_priv),
        .reason(reason), .vec_off(vec_off)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic f, input logic u, input logic p,
                         input logic s, input logic [9:0] n, input logic pr, input logic fe);
        in_valid = v; is_fp = f; is_unimpl = u; is_priv_only = p;
        is_spr_move = s; spr_num = n; msr_pr = pr; msr_fp = fe;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h0, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset holds every output at zero even with a valid request present
        check("R10 reset req_emul", {31'b0, req_emul}, 32'h0);
        check("R10 reset req_priv", {31'b0, req_priv}, 32'h0);
        check("R10 reset vec_off",  {12'b0, vec_off}, 32'h0);
        check("R10 reset reason",   reason, 32'h0);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h0, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        // R10: latency, no change before the capturing edge
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h0, 1'b0, 1'b1);
        #1;
        check("R10 no early change", {31'b0, req_emul}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R10 one-cycle latency", {31'b0, req_emul}, 32'h1);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'h0, 1'b1, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R9 drop after valid low", {31'b0, req_emul}, 32'h0);

        for (int c = 0; c < 256; c++) begin
            for (int k = 0; k < 3; k++) begin
                logic v, f, u, p, s, top, pr, fe;
                logic [8:0] low;
                logic e_emul, e_priv;
                logic [31:0] e_rsn;
                logic [19:0] e_vec;
                string tag;
                {v, f, u, p, s, top, pr, fe} = c[7:0];
                low = (k == 0) ? 9'h000 : ((k == 1) ? 9'h155 : 9'h1FF);
                drive(v, f, u, p, s, {top, low}, pr, fe);
                e_emul = v & (f | u);
                e_priv = v & pr & ~e_emul & (p | (s & top));
                e_vec  = e_emul ? 20'h01000 : (e_priv ? 20'h00700 : 20'h0);
                e_rsn  = e_priv ? 32'h0004_0000 : 32'h0;
                if (!v)                      tag = "R9";
                else if (f && (p || s))      tag = "R8";
                else if (f)                  tag = "R1";
                else if (u)                  tag = "R2";
                else if (p)                  tag = "R3";
                else if (s && top)           tag = "R4";
                else if (s)                  tag = "R5";
                else                         tag = "R9 idle";
                @(posedge clk);
                @(negedge clk);
                check({tag, " req_emul"}, {31'b0, req_emul}, {31'b0, e_emul});
                check({tag, " req_priv"}, {31'b0, req_priv}, {31'b0, e_priv});
                check("R6 vec_off", {12'b0, vec_off}, {12'b0, e_vec});
                check("R7 reason", reason, e_rsn);
                check("R8 at most one", {31'b0, req_emul & req_priv}, 32'h0);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule